// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block keeps the return addresses of a small microcontroller core in a four-slot hardware stack. A subroutine call pushes the address presented with the push strobe. A return pops the most recent entry, and that entry appears on the popped-address output in the same cycle as the pop strobe, ready to reload the program counter.

The block also decides when a pending interrupt may be taken. A request is latched. It is granted in the first cycle in which the stack has a free slot and the core is issuing no call or return. The grant pushes the current address input, which is the interrupted program counter.

A call made on a full stack still goes through, and the oldest stored address is silently lost. An interrupt arriving on a full stack waits until a return frees a slot. A pop on an empty stack is flagged and leaves the stack unchanged. A push and a pop in the same cycle replace the top entry.

Top module: `rstk`

## Requirements
- R1: After reset the stack is empty: count_o=0, empty_o=1, full_o=0, underflow_o=0, irq_pend_o=0, and irq_ack_o=0 while irq_req_i is low.
- R2: The stack is last-in first-out. In a cycle with pop_i=1 and push_i=0 on a non-empty stack, pop_addr_o shows the most recently pushed address that is still stored, and count_o drops by one at the next edge.
- R3: The stack holds DEPTH (default 4) entries. full_o is 1 exactly when count_o equals DEPTH, and count_o never exceeds DEPTH.
- R4: A push on a full stack stores the new address, keeps count_o at DEPTH, and discards the oldest entry. The following pops return the newest DEPTH addresses in reverse order of pushing.
- R5: A pop on an empty stack leaves count_o at 0 and raises underflow_o for exactly the one cycle after it.
- R6: When an interrupt is pending (irq_req_i high now, or latched earlier), the stack is not full, and push_i and pop_i are both low, irq_ack_o is 1 in that same cycle. addr_i is pushed at the next edge and the latched request clears.
- R7: On a full stack a request is latched (irq_pend_o=1 from the next cycle) and irq_ack_o stays 0. After a pop frees a slot, the request is granted in the next cycle with push_i and pop_i low.
- R8: irq_ack_o is 0 in any cycle with push_i or pop_i high. A request made in such a cycle stays pending.
- R9: push_i and pop_i together on a non-empty stack replace the top entry with addr_i, and count_o is unchanged.
- R10: push_i and pop_i together on an empty stack store addr_i as the only entry (count_o becomes 1) and raise underflow_o for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call strobe |
| pop_i | input | 1 | Return strobe |
| addr_i | input | AW | Address to push (call target return or interrupted PC) |
| irq_req_i | input | 1 | Unmasked interrupt request |
| pop_addr_o | output | AW | Current top entry, the restored PC during a pop |
| irq_ack_o | output | 1 | Interrupt grant; pushes addr_i this cycle |
| irq_pend_o | output | 1 | Latched request not yet granted |
| count_o | output | $clog2(DEPTH+1) | Number of stored entries |
| full_o | output | 1 | Stack holds DEPTH entries |
| empty_o | output | 1 | Stack holds no entries |
| underflow_o | output | 1 | One-cycle flag after a pop on an empty stack |

## Verification
The bench goes after the full-stack cases. In a design that lets count wrap or that drops the wrong entry, a fifth call followed by four returns yields the wrong addresses or a count that is not four. An interrupt raised on a full stack must be held and then granted only after a return. A design that grants at once would overwrite a live return address, and one that forgets the latch would never take the interrupt. The bench also checks simultaneous push and pop on both empty and non-empty stacks, where a design that treats them as two operations moves the count. Finally, a long pseudo-random sweep compares every output against a shift-register model built in the bench.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_REPL
  } stk_op_e;
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  output logic [PW-1:0] wptr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          underflow_o
);
  logic [PW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          uf_q, uf_d;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    uf_d   = 1'b0;
    unique case (op_i)
      OP_PUSH: begin
        wptr_d = wptr_q + 1'b1;
        if (!full_o) cnt_d = cnt_q + 1'b1;  // full: oldest slot overwritten
      end
      OP_POP: begin
        if (empty_o) uf_d = 1'b1;
        else begin
          wptr_d = wptr_q - 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      OP_REPL: begin
        if (empty_o) begin
          uf_d   = 1'b1;
          wptr_d = wptr_q + 1'b1;
          cnt_d  = CW'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
      uf_q   <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
      uf_q   <= uf_d;
    end
  end

  assign wptr_o      = wptr_q;
  assign count_o     = cnt_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/rstk_mem.sv
module rstk_mem
  import rstk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW = 11,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [PW-1:0] wptr_i,
  input  logic          empty_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o
);
  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] top_idx, wr_idx;
  logic          wr_en;

  assign top_idx = wptr_i - 1'b1;
  assign wr_en   = (op_i == OP_PUSH) || (op_i == OP_REPL);
  assign wr_idx  = (op_i == OP_REPL && !empty_i) ? top_idx : wptr_i;
  assign top_o   = slot_q[top_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (wr_en && wr_idx == PW'(i)) slot_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rstk_irq.sv
module rstk_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic full_i,
  input  logic busy_i,
  output logic ack_o,
  output logic pend_o
);
  logic pend_q, want;

  assign want  = pend_q | req_i;
  assign ack_o = want & ~full_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want & ~ack_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rstk.sv
module rstk
  import rstk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW = 11,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  input  logic          irq_req_i,
  output logic [AW-1:0] pop_addr_o,
  output logic          irq_ack_o,
  output logic          irq_pend_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          underflow_o
);
  stk_op_e       op;
  logic [PW-1:0] wptr;

  rstk_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .full_i (full_o),
    .busy_i (push_i | pop_i),
    .ack_o  (irq_ack_o),
    .pend_o (irq_pend_o)
  );

  always_comb begin
    if (irq_ack_o)            op = OP_PUSH;
    else if (push_i && pop_i) op = OP_REPL;
    else if (push_i)          op = OP_PUSH;
    else if (pop_i)           op = OP_POP;
    else                      op = OP_IDLE;
  end

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .wptr_o      (wptr),
    .count_o     (count_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .underflow_o (underflow_o)
  );

  rstk_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wptr_i  (wptr),
    .empty_i (empty_o),
    .wdata_i (addr_i),
    .top_o   (pop_addr_o)
  );
endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          irq_ack_o,
  input logic          irq_pend_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          underflow_o,
  input logic [CW-1:0] count_o
);
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  // R7
  full_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !irq_ack_o);
  // R8
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |-> !irq_ack_o);
  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> (underflow_o && count_o == '0));
  // R2
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> count_o == $past(count_o) + 1'b1);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (!irq_pend_o && !empty_o));
  // R9
  replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=> $stable(count_o));
endmodule

bind rstk rstk_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .irq_ack_o   (irq_ack_o),
  .irq_pend_o  (irq_pend_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .underflow_o (underflow_o),
  .count_o     (count_o)
);

// File: tb/rstk_test.sv
module rstk_test;
  localparam int AW = 11;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic push = 1'b0, pop = 1'b0, req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] pop_addr_o;
  logic irq_ack_o, irq_pend_o, full_o, empty_o, underflow_o;
  logic [2:0] count_o;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m [DEPTH];
  int mcnt = 0;
  logic mpend = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rstk #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push), .pop_i(pop), .addr_i(addr),
    .irq_req_i(req), .pop_addr_o(pop_addr_o), .irq_ack_o(irq_ack_o),
    .irq_pend_o(irq_pend_o), .count_o(count_o), .full_o(full_o),
    .empty_o(empty_o), .underflow_o(underflow_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic p, logic q, logic r, logic [AW-1:0] a);
    logic ack, uf;
    @(negedge clk);
    push = p; pop = q; req = r; addr = a;
    #1;
    ack = (mpend || r) && mcnt < DEPTH && !p && !q;
    chk("R6 R7 R8 irq_ack", 32'(irq_ack_o), 32'(ack));
    if (q && mcnt > 0) chk("R2 R4 pop_addr", 32'(pop_addr_o), 32'(m[mcnt-1]));
    uf = 1'b0;
    if (ack) begin
      m[mcnt] = a; mcnt++;
    end else if (p && q) begin
      if (mcnt == 0) begin m[0] = a; mcnt = 1; uf = 1'b1; end
      else m[mcnt-1] = a;
    end else if (p) begin
      if (mcnt == DEPTH) begin
        for (int k = 0; k < DEPTH - 1; k++) m[k] = m[k+1];
        m[DEPTH-1] = a;
      end else begin
        m[mcnt] = a; mcnt++;
      end
    end else if (q) begin
      if (mcnt == 0) uf = 1'b1;
      else mcnt--;
    end
    mpend = (mpend || r) && !ack;
    @(posedge clk); #1;
    chk("R3 R4 R9 R10 count", 32'(count_o), 32'(mcnt));
    chk("R3 full", 32'(full_o), 32'(mcnt == DEPTH));
    chk("R1 R5 empty", 32'(empty_o), 32'(mcnt == 0));
    chk("R5 R10 underflow", 32'(underflow_o), 32'(uf));
    chk("R7 pend", 32'(irq_pend_o), 32'(mpend));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int k = 0; k < DEPTH; k++) m[k] = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 count", 32'(count_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 underflow", 32'(underflow_o), 0);
    chk("R1 pend", 32'(irq_pend_o), 0);
    chk("R1 ack", 32'(irq_ack_o), 0);
    // fill, overfill, drain past empty
    for (int i = 1; i <= 5; i++) cyc(1, 0, 0, AW'(11'h100 + i));
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, '0);
    // interrupt on full stack, released by a pop
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, AW'(11'h200 + i));
    cyc(0, 0, 1, 11'h3aa);
    cyc(0, 0, 0, '0);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 0, 11'h3ab);
    // replace on non-empty, then on empty
    cyc(1, 1, 0, 11'h055);
    cyc(0, 1, 0, '0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);
    cyc(1, 1, 0, 11'h066);
    cyc(0, 1, 0, '0);
    // request during call and return cycles
    cyc(1, 0, 1, 11'h011);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 0, 11'h022);
    // pseudo-random sweep
    lfsr = 16'hace1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & ~lfsr[5], lfsr[1] & lfsr[2], lfsr[4] & lfsr[7] & lfsr[9],
          lfsr[14:4]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule